// File: doc/BRIEF.md
# Fleet Placement Cursor Controller

This block runs the setup phase of one player in a two-player grid battle game. It receives debounced single-cycle pulses from four direction buttons and from rotate, place and undo buttons. It moves an anchor cursor over a 10 by 10 board and tracks whether the ship being placed lies horizontally or vertically. Any step or turn that would push a cell of the ship past the board edge is refused. The five ships go down in a fixed order of lengths.

When a ship is placed, its anchor cell is sent to a host as a single 7-bit cell code next to a 4-bit phase code. The code is held until the host has raised and then dropped its acknowledge line, so the host cannot miss it. The button rate is set by an enable input, not by a second clock, so every flop runs on one clock. After the fifth ship is acknowledged the controller freezes until reset.

Top module: `fleet_setup_ctrl`

## Requirements
- R1: Ships are placed in the index order 0..4 with lengths 5, 4, 3, 3, 2 shown on ship_len_o. Each new ship starts horizontal (vertical_o=0) at the previous cursor row. Its column is kept, or clamped down to 10 minus the length if the ship would not fit otherwise.
- R2: After reset the cursor is at row 0, column 0, horizontal, ship index 0, state_o=1, loc_valid_o=0, loc_code_o=0 and setup_done_o=0.
- R3: A rotate pulse toggles vertical_o and leaves the anchor in place. A horizontal ship covers columns col..col+L-1 of its row. A vertical ship covers rows row..row+L-1 of its column, with row 0 at the bottom.
- R4: Up adds one to the row, down subtracts one from the row, right adds one to the column and left subtracts one from the column. A move or rotation that would put any ship cell outside rows and columns 0..9 leaves the cursor and the orientation unchanged.
- R5: A place pulse in state 1 sets loc_valid_o=1, loc_code_o=row*10+col and state_o=2 at the next clock edge.
- R6: While state_o=2, the direction, rotate, place and undo pulses have no effect.
- R7: In state 2, loc_valid_o and loc_code_o hold until an edge where go_i is low after it was high at the previous edge. At that edge loc_valid_o and loc_code_o clear to 0 and the next ship becomes active.
- R8: In state 1 with ship index above 0, an undo pulse lowers the index by one and restores that ship's placed row, column and orientation. At index 0, undo has no effect.
- R9: Button pulses act only in cycles where btn_en_i is high. go_i is sampled in every cycle.
- R10: When the fifth ship is acknowledged, state_o becomes 3 and setup_done_o becomes 1. From then until reset, every button pulse has no effect.
- R11: When several pulses arrive in the same enabled cycle, only the highest-priority one acts. The order is undo, place, rotate, up, down, left, right. An undo at index 0 still blocks the pulses below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_en_i | input | 1 | Button-rate enable |
| up_i | input | 1 | Move-up pulse |
| down_i | input | 1 | Move-down pulse |
| left_i | input | 1 | Move-left pulse |
| right_i | input | 1 | Move-right pulse |
| rotate_i | input | 1 | Orientation toggle pulse |
| place_i | input | 1 | Commit pulse |
| undo_i | input | 1 | Take back the last ship |
| go_i | input | 1 | Host acknowledge |
| cur_row_o | output | 4 | Anchor row |
| cur_col_o | output | 4 | Anchor column |
| vertical_o | output | 1 | 1 when the active ship is vertical |
| ship_idx_o | output | 3 | Active ship index |
| ship_len_o | output | 3 | Active ship length |
| loc_valid_o | output | 1 | Committed location present |
| loc_code_o | output | 7 | Committed cell code row*10+col |
| state_o | output | 4 | Phase: 1 placing, 2 reporting, 3 done |
| setup_done_o | output | 1 | Fleet complete |

## Verification
The assertions assume that go_i is driven by a host that raises it only after it sees loc_valid_o. They also assume that the button pulses are synchronous to clk_i and free of bounce. The bench drives every input at the falling edge and raises go_i for a random number of cycles only while the controller is reporting. The random stimulus mixes single pulses with occasional simultaneous ones and with enable-low cycles, so every check sees legal, clean input levels.

// File: rtl/fleet_pkg.sv
package fleet_pkg;
  localparam int BOARD_N   = 10;
  localparam int NUM_SHIPS = 5;
  localparam int COORD_W   = $clog2(BOARD_N);
  localparam int CODE_W    = $clog2(BOARD_N * BOARD_N);
  localparam int IDX_W     = $clog2(NUM_SHIPS);
  localparam int LEN_W     = 3;

  typedef enum logic [3:0] {
    ST_PLACE  = 4'h1,
    ST_REPORT = 4'h2,
    ST_DONE   = 4'h3
  } setup_st_e;

  typedef struct packed {
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
    logic               vert;
  } anchor_t;

  function automatic logic [LEN_W-1:0] ship_len(input int unsigned idx);
    case (idx)
      0:       return LEN_W'(5);
      1:       return LEN_W'(4);
      2, 3:    return LEN_W'(3);
      default: return LEN_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/fleet_fit_check.sv
module fleet_fit_check
  import fleet_pkg::*;
(
  input  logic [COORD_W:0]  row_i,
  input  logic [COORD_W:0]  col_i,
  input  logic              vert_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              fits_o
);
  localparam int EW = COORD_W + 2;

  logic [EW-1:0] span_end;

  always_comb begin
    span_end = (vert_i ? EW'(row_i) : EW'(col_i)) + EW'(len_i);
    fits_o   = (EW'(row_i) < EW'(BOARD_N)) && (EW'(col_i) < EW'(BOARD_N)) &&
               (span_end <= EW'(BOARD_N));
  end
endmodule

// File: rtl/fleet_cursor_next.sv
module fleet_cursor_next
  import fleet_pkg::*;
(
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic               vert_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               up_i,
  input  logic               down_i,
  input  logic               left_i,
  input  logic               right_i,
  input  logic               rotate_i,
  output logic [COORD_W-1:0] row_o,
  output logic [COORD_W-1:0] col_o,
  output logic               vert_o
);
  localparam int CW = COORD_W + 1;

  logic [CW-1:0] cand_row, cand_col;
  logic          cand_vert, cand_ok, fits, take;

  // priority: rotate, up, down, left, right
  always_comb begin
    cand_row  = CW'(row_i);
    cand_col  = CW'(col_i);
    cand_vert = vert_i;
    cand_ok   = 1'b1;
    if (rotate_i) begin
      cand_vert = ~vert_i;
    end else if (up_i) begin
      cand_row = cand_row + CW'(1);
    end else if (down_i) begin
      cand_ok  = (row_i != '0);
      cand_row = cand_row - CW'(1);
    end else if (left_i) begin
      cand_ok  = (col_i != '0);
      cand_col = cand_col - CW'(1);
    end else if (right_i) begin
      cand_col = cand_col + CW'(1);
    end
  end

  fleet_fit_check u_fit (
    .row_i (cand_row),
    .col_i (cand_col),
    .vert_i(cand_vert),
    .len_i (len_i),
    .fits_o(fits)
  );

  assign take   = cand_ok & fits;
  assign row_o  = take ? cand_row[COORD_W-1:0] : row_i;
  assign col_o  = take ? cand_col[COORD_W-1:0] : col_i;
  assign vert_o = take ? cand_vert : vert_i;
endmodule

// File: rtl/fleet_anchor_store.sv
module fleet_anchor_store
  import fleet_pkg::*;
#(
  parameter int DEPTH = NUM_SHIPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  anchor_t          wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output anchor_t          rd_data_o
);
  anchor_t slot_vec [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    anchor_t slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     slot_q <= wr_data_i;
    end
    assign slot_vec[g] = slot_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = slot_vec[i];
    end
  end
endmodule

// File: rtl/fleet_setup_ctrl.sv
module fleet_setup_ctrl
  import fleet_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               btn_en_i,
  input  logic               up_i,
  input  logic               down_i,
  input  logic               left_i,
  input  logic               right_i,
  input  logic               rotate_i,
  input  logic               place_i,
  input  logic               undo_i,
  input  logic               go_i,
  output logic [COORD_W-1:0] cur_row_o,
  output logic [COORD_W-1:0] cur_col_o,
  output logic               vertical_o,
  output logic [IDX_W-1:0]   ship_idx_o,
  output logic [LEN_W-1:0]   ship_len_o,
  output logic               loc_valid_o,
  output logic [CODE_W-1:0]  loc_code_o,
  output logic [3:0]         state_o,
  output logic               setup_done_o
);
  localparam int CW = COORD_W + 2;

  setup_st_e          st_q;
  logic [COORD_W-1:0] row_q, col_q;
  logic               vert_q;
  logic [IDX_W-1:0]   idx_q;
  logic               valid_q;
  logic [CODE_W-1:0]  code_q;
  logic               go_q;

  logic [LEN_W-1:0]   len_cur, len_next;
  logic               en_place, do_undo, do_place, mv_en, go_fall, last_ship;
  logic [COORD_W-1:0] mv_row, mv_col, next_col;
  logic               mv_vert;
  anchor_t            rd_anchor;

  assign len_cur   = ship_len(int'(idx_q));
  assign len_next  = ship_len(int'(idx_q) + 1);
  assign en_place  = (st_q == ST_PLACE) && btn_en_i;
  assign do_undo   = en_place && undo_i && (idx_q != '0);
  assign do_place  = en_place && !undo_i && place_i;
  assign mv_en     = en_place && !undo_i && !place_i;
  assign go_fall   = (st_q == ST_REPORT) && go_q && !go_i;
  assign last_ship = (idx_q == IDX_W'(NUM_SHIPS - 1));

  // column clamp for the next, possibly shorter, horizontal ship
  assign next_col = (CW'(col_q) + CW'(len_next) > CW'(BOARD_N)) ?
                    COORD_W'(BOARD_N - int'(len_next)) : col_q;

  fleet_cursor_next u_next (
    .row_i   (row_q),
    .col_i   (col_q),
    .vert_i  (vert_q),
    .len_i   (len_cur),
    .up_i    (mv_en & up_i),
    .down_i  (mv_en & down_i),
    .left_i  (mv_en & left_i),
    .right_i (mv_en & right_i),
    .rotate_i(mv_en & rotate_i),
    .row_o   (mv_row),
    .col_o   (mv_col),
    .vert_o  (mv_vert)
  );

  fleet_anchor_store u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (do_place),
    .wr_idx_i (idx_q),
    .wr_data_i('{row: row_q, col: col_q, vert: vert_q}),
    .rd_idx_i (idx_q - IDX_W'(1)),
    .rd_data_o(rd_anchor)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PLACE;
      row_q   <= '0;
      col_q   <= '0;
      vert_q  <= 1'b0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      code_q  <= '0;
      go_q    <= 1'b0;
    end else begin
      go_q <= go_i;
      case (st_q)
        ST_PLACE: begin
          if (do_undo) begin
            idx_q  <= idx_q - IDX_W'(1);
            row_q  <= rd_anchor.row;
            col_q  <= rd_anchor.col;
            vert_q <= rd_anchor.vert;
          end else if (do_place) begin
            valid_q <= 1'b1;
            code_q  <= CODE_W'(row_q) * CODE_W'(BOARD_N) + CODE_W'(col_q);
            st_q    <= ST_REPORT;
          end else begin
            row_q  <= mv_row;
            col_q  <= mv_col;
            vert_q <= mv_vert;
          end
        end
        ST_REPORT: begin
          if (go_fall) begin
            valid_q <= 1'b0;
            code_q  <= '0;
            if (last_ship) begin
              st_q <= ST_DONE;
            end else begin
              idx_q  <= idx_q + IDX_W'(1);
              vert_q <= 1'b0;
              col_q  <= next_col;
              st_q   <= ST_PLACE;
            end
          end
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  assign cur_row_o    = row_q;
  assign cur_col_o    = col_q;
  assign vertical_o   = vert_q;
  assign ship_idx_o   = idx_q;
  assign ship_len_o   = len_cur;
  assign loc_valid_o  = valid_q;
  assign loc_code_o   = code_q;
  assign state_o      = st_q;
  assign setup_done_o = (st_q == ST_DONE);
endmodule

// File: rtl/fleet_setup_checker.sv
module fleet_setup_checker
  import fleet_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               go_i,
  input logic [COORD_W-1:0] cur_row_o,
  input logic [COORD_W-1:0] cur_col_o,
  input logic               vertical_o,
  input logic [IDX_W-1:0]   ship_idx_o,
  input logic [LEN_W-1:0]   ship_len_o,
  input logic               loc_valid_o,
  input logic [CODE_W-1:0]  loc_code_o,
  input logic [3:0]         state_o,
  input logic               setup_done_o
);
  logic [COORD_W+1:0] span_end;
  assign span_end = (vertical_o ? (COORD_W+2)'(cur_row_o) : (COORD_W+2)'(cur_col_o))
                    + (COORD_W+2)'(ship_len_o);

  AST_SHIP_ON_BOARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    span_end <= (COORD_W+2)'(BOARD_N)); // R4

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_valid_o |-> loc_code_o < CODE_W'(BOARD_N * BOARD_N)); // R5

  AST_HOLD_WHILE_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_valid_o && go_i) |=> loc_valid_o); // R7

  AST_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_valid_o && $past(loc_valid_o)) |-> $stable(loc_code_o)); // R7

  AST_REPORT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'h2 && go_i) |=> ($stable(cur_row_o) && $stable(cur_col_o) &&
                                   $stable(ship_idx_o))); // R6

  AST_NEW_SHIP_HORIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ship_idx_o > $past(ship_idx_o)) |-> !vertical_o); // R1

  AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_o |=> (setup_done_o && $stable(cur_row_o) && $stable(cur_col_o) &&
                      $stable(vertical_o) && $stable(ship_idx_o))); // R10
endmodule

bind fleet_setup_ctrl fleet_setup_checker u_chk (.*);

// File: tb/fleet_setup_ctrl_test.sv
module fleet_setup_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, up = 1'b0, dn = 1'b0, lf = 1'b0, rt = 1'b0;
  logic rot = 1'b0, pl = 1'b0, un = 1'b0, go = 1'b0;
  logic [3:0] row_o, col_o, st_o;
  logic vert_o, valid_o, done_o;
  logic [2:0] idx_o, len_o;
  logic [6:0] code_o;

  int tests = 0, fails = 0;
  int m_st, m_row, m_col, m_vert, m_idx, m_valid, m_code, m_goq;
  int sr[5], sc[5], sv[5];

  always #10 clk = ~clk;

  fleet_setup_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .btn_en_i(en), .up_i(up), .down_i(dn),
    .left_i(lf), .right_i(rt), .rotate_i(rot), .place_i(pl), .undo_i(un), .go_i(go),
    .cur_row_o(row_o), .cur_col_o(col_o), .vertical_o(vert_o), .ship_idx_o(idx_o),
    .ship_len_o(len_o), .loc_valid_o(valid_o), .loc_code_o(code_o), .state_o(st_o),
    .setup_done_o(done_o)
  );

  function automatic int m_len(int i);
    return (i == 0) ? 5 : (i == 1) ? 4 : (i <= 3) ? 3 : 2;
  endfunction

  function automatic bit fits(int r, int c, int v, int l);
    if (r < 0 || c < 0 || r > 9 || c > 9) return 0;
    return v != 0 ? (r + l <= 10) : (c + l <= 10);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4", "row", int'(row_o), m_row);
    chk("R4", "col", int'(col_o), m_col);
    chk("R3", "vertical", int'(vert_o), m_vert);
    chk("R1", "ship index", int'(idx_o), m_idx);
    chk("R1", "ship length", int'(len_o), m_len(m_idx));
    chk("R7", "valid", int'(valid_o), m_valid);
    chk("R5", "code", int'(code_o), m_code);
    chk("R6", "state", int'(st_o), m_st);
    chk("R10", "done", int'(done_o), m_st == 3 ? 1 : 0);
  endtask

  // reference model of one clock edge
  task automatic model(bit e, bit u, bit d, bit l, bit r, bit ro, bit p, bit n, bit g);
    int len = m_len(m_idx);
    if (m_st == 1 && e) begin
      if (n) begin
        if (m_idx > 0) begin
          m_idx--; m_row = sr[m_idx]; m_col = sc[m_idx]; m_vert = sv[m_idx];
        end
      end else if (p) begin
        sr[m_idx] = m_row; sc[m_idx] = m_col; sv[m_idx] = m_vert;
        m_valid = 1; m_code = m_row * 10 + m_col; m_st = 2;
      end else if (ro) begin
        if (fits(m_row, m_col, 1 - m_vert, len)) m_vert = 1 - m_vert;
      end else if (u) begin
        if (fits(m_row + 1, m_col, m_vert, len)) m_row++;
      end else if (d) begin
        if (fits(m_row - 1, m_col, m_vert, len)) m_row--;
      end else if (l) begin
        if (fits(m_row, m_col - 1, m_vert, len)) m_col--;
      end else if (r) begin
        if (fits(m_row, m_col + 1, m_vert, len)) m_col++;
      end
    end else if (m_st == 2 && m_goq == 1 && !g) begin
      m_valid = 0; m_code = 0;
      if (m_idx == 4) m_st = 3;
      else begin
        m_idx++; m_vert = 0;
        if (m_col + m_len(m_idx) > 10) m_col = 10 - m_len(m_idx);
        m_st = 1;
      end
    end
    m_goq = g;
  endtask

  // drive at falling edge, compare at next falling edge
  task automatic step(bit e, bit u, bit d, bit l, bit r, bit ro, bit p, bit n, bit g);
    en = e; up = u; dn = d; lf = l; rt = r; rot = ro; pl = p; un = n; go = g;
    model(e, u, d, l, r, ro, p, n, g);
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic btn(bit u, bit d, bit l, bit r, bit ro, bit p, bit n);
    step(1, u, d, l, r, ro, p, n, 0);
  endtask

  task automatic ack();
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {en, up, dn, lf, rt, rot, pl, un, go} = '0;
    repeat (2) @(negedge clk);
    m_st = 1; m_row = 0; m_col = 0; m_vert = 0; m_idx = 0;
    m_valid = 0; m_code = 0; m_goq = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R2 reset state
    chk("R2", "reset row", int'(row_o), 0);
    chk("R2", "reset col", int'(col_o), 0);
    chk("R2", "reset state", int'(st_o), 1);
    chk("R2", "reset valid", int'(valid_o), 0);
    chk("R2", "reset done", int'(done_o), 0);
    chk("R2", "reset len", int'(len_o), 5);

    btn(0, 0, 1, 0, 0, 0, 0);                     // R4 left at col 0 ignored
    chk("R4", "left at edge", int'(col_o), 0);
    btn(0, 1, 0, 0, 0, 0, 0);                     // R4 down at row 0 ignored
    chk("R4", "down at edge", int'(row_o), 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);              // R9 enable low
    chk("R9", "right with enable low", int'(col_o), 0);
    btn(0, 0, 0, 0, 1, 0, 0);                     // R3 rotate to vertical
    chk("R3", "rotate to vertical", int'(vert_o), 1);
    for (int i = 0; i < 6; i++) btn(1, 0, 0, 0, 0, 0, 0);
    chk("R4", "up stops at row 5 for vertical len 5", int'(row_o), 5);
    btn(0, 0, 0, 0, 1, 1, 0);                     // R11 place beats rotate
    chk("R11", "place wins over rotate", int'(st_o), 2);
    chk("R5", "code of (5,0)", int'(code_o), 50);
    btn(0, 0, 0, 1, 0, 0, 1);                     // R6 ignored while reporting
    chk("R6", "undo/right ignored while reporting", int'(col_o), 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7", "held while go high", int'(valid_o), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "cleared after go falls", int'(valid_o), 0);
    chk("R1", "second ship horizontal", int'(vert_o), 0);
    chk("R1", "second ship length", int'(len_o), 4);
    for (int i = 0; i < 9; i++) btn(0, 0, 0, 1, 0, 0, 0);
    chk("R4", "right stops at col 6 for len 4", int'(col_o), 6);
    btn(1, 0, 0, 0, 1, 0, 0);                     // R11 rotate beats up
    chk("R11", "rotate wins over up", int'(row_o), 5);
    btn(0, 0, 0, 0, 0, 0, 1);                     // R8 undo restores ship 0
    chk("R8", "undo index", int'(idx_o), 0);
    chk("R8", "undo restores vertical", int'(vert_o), 1);
    btn(0, 0, 0, 0, 0, 0, 1);
    chk("R8", "undo at index 0 ignored", int'(idx_o), 0);
    btn(0, 0, 0, 0, 0, 0, 1);                     // re-place ship 0 at (5,0) vertical
    btn(0, 0, 0, 0, 0, 1, 0); ack();
    for (int i = 0; i < 9; i++) btn(0, 0, 0, 1, 0, 0, 0);
    btn(0, 0, 0, 0, 0, 1, 0); ack();              // ship 1 at col 6
    chk("R1", "clamp for len 3 keeps col 6", int'(col_o), 6);
    btn(0, 0, 0, 1, 0, 0, 0);
    btn(0, 0, 0, 0, 0, 1, 0); ack();
    btn(0, 0, 0, 0, 0, 1, 0); ack();
    chk("R1", "last ship length 2", int'(len_o), 2);
    btn(0, 0, 0, 0, 0, 1, 0); ack();
    chk("R10", "done after fifth ack", int'(done_o), 1);
    btn(0, 0, 1, 0, 1, 1, 1);
    chk("R10", "pulses ignored when done", int'(st_o), 3);

    // R1 clamp from vertical at column 9
    do_reset();
    for (int i = 0; i < 9; i++) btn(0, 0, 0, 1, 0, 0, 0);
    btn(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 9; i++) btn(0, 0, 0, 1, 0, 0, 0);
    chk("R1", "vertical ship reaches col 9", int'(col_o), 9);
    btn(0, 0, 0, 0, 0, 1, 0); ack();
    chk("R1", "clamped to 10-4", int'(col_o), 6);

    // constrained random rounds
    for (int rnd = 0; rnd < 6; rnd++) begin
      do_reset();
      for (int k = 0; k < 1500; k++) begin
        bit e, g;
        bit [6:0] p;
        int sel;
        e = ($urandom % 10) != 0;
        sel = $urandom % 20;
        p = '0;
        if (sel < 14) p[sel % 5] = 1'b1;        // u d l r rot
        else if (sel < 17) p[5] = 1'b1;         // place
        else if (sel < 18) p[6] = 1'b1;         // undo
        else if (sel < 19) p = 7'($urandom);    // several at once
        g = (m_st == 2) ? (($urandom % 3) != 0) : 1'b0;
        step(e, p[0], p[1], p[2], p[3], p[4], p[5], p[6], g);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule